// File: doc/BRIEF.md
# Quarter-Rate Resonator Decimating Tuner

This block is a streaming front end for a sampled radio input. Each unsigned converter sample becomes a signed value. It then passes through a recursive resonator that peaks at one quarter of the input sample rate. The resonator output is kept only at the last sample of every group of M accepted samples. A two-tap equaliser runs at the reduced rate and flattens the sharp peak of the resonator into a usable passband.

With the default M of 40, a 2 MHz input stream becomes a 50 kHz output stream centred on 500 kHz. Signals a few kHz either side of the centre pass with gain. Signals far from the centre are strongly reduced.

The resonator feeds back only the output from two samples earlier, so it needs a single constant multiplier. The equaliser coefficient is derived from the resonator coefficient and M. This places its notch at one quarter of the output rate, which counters the droop of the resonator's response.

Top module: `qtr_tuner`

## Requirements
- R1: An accepted 16-bit sample is made signed by subtracting 32768, which is the same as inverting its most significant bit.
- R2: The resonator computes y = x − round(B1·y[n−2]). B1 is a signed Q1.15 constant with default 32735. A product is rounded by adding 2^14 and then shifting right arithmetically by 15.
- R3: The resonator result saturates to the signed 24-bit range [−8388608, 8388607] instead of wrapping.
- R4: Exactly one output is produced for every M accepted samples. The output uses the resonator result of the last sample of the group, and the other results of the group reach no output.
- R5: The equaliser computes z = y_d[k] + round(B2·y_d[k−2]). Its delay line holds past decimated resonator results. B2 = 32768 − (32768 − B1)·M, which is 31448 by default. z saturates to the signed 24-bit range.
- R6: out_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the M-th sample of a group. out_data holds its value while out_valid is low.
- R7: A cycle with in_valid low changes neither the resonator state, the equaliser state nor the group count.
- R8: A synchronous reset clears both delay lines, the group count and the outputs. The first output after reset follows exactly M accepted samples.
- R9: Resonator and equaliser state carry across group boundaries and are never cleared except by reset.
- R10: After settling, a tone 8 kHz from the centre yields at least 64 times the output energy of a tone of equal amplitude 207 kHz from the centre.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample accepted this cycle |
| in_data | input | 16 | Unsigned converter sample |
| out_valid | output | 1 | One-cycle pulse marking a new decimated result |
| out_data | output | 24 | Signed equaliser result |

## Verification
The bench compares every output against a bit-exact integer model. A wrong rounding constant, a dropped sign inversion, a filter that kept the first sample of a group instead of the last, or an equaliser that fed back its own output would each show as a mismatch within a few groups. Idle gaps are mixed into the stimulus, so a design that advanced its count or state on an idle cycle would put out_valid in the wrong cycle. A square wave at one quarter of the input rate drives the resonator into its limits: a wrapping accumulator would flip sign where the saturating one stays pinned at the rail. A reset in the middle of a group checks that the count restarts, and that a design keeping stale count or state emits early or wrong values.

// File: rtl/qtr_tuner.sv
module qtr_tuner #(
  parameter int IN_W  = 16,
  parameter int GUARD = 8,
  parameter int M     = 40,
  parameter int B1    = 32735
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [IN_W-1:0]                  in_data,
  output logic                             out_valid,
  output logic signed [IN_W+GUARD-1:0]     out_data
);
  localparam int SW    = IN_W + GUARD;
  localparam int CW    = 16;
  localparam int FRAC  = CW - 1;
  localparam int W     = SW + CW;
  localparam int B2    = (1 << FRAC) - ((1 << FRAC) - B1) * M;
  localparam int CNT_W = (M > 2) ? $clog2(M) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(M - 1);
  localparam logic signed [CW-1:0] B1C = CW'(B1);
  localparam logic signed [CW-1:0] B2C = CW'(B2);
  localparam logic signed [W-1:0]  HALF = W'(1) <<< (FRAC - 1);

  function automatic logic signed [W-1:0] qmul(input logic signed [SW-1:0] a,
                                               input logic signed [CW-1:0] c);
    logic signed [W-1:0] aw, cw, p;
    aw = $signed({{CW{a[SW-1]}}, a});
    cw = $signed({{SW{c[CW-1]}}, c});
    p  = aw * cw + HALF;
    return p >>> FRAC;
  endfunction

  function automatic logic signed [SW-1:0] clip(input logic signed [W-1:0] v);
    if (&v[W-1:SW-1] || ~|v[W-1:SW-1]) return v[SW-1:0];
    else if (v[W-1]) return {1'b1, {(SW-1){1'b0}}};
    else return {1'b0, {(SW-1){1'b1}}};
  endfunction

  logic signed [SW-1:0] y1, y2, d1, d2;
  logic [CNT_W-1:0]     cnt;

  logic signed [IN_W-1:0] x;
  logic signed [W-1:0]    xw, acc1, acc2;
  logic signed [SW-1:0]   ynew, z;

  assign x    = {~in_data[IN_W-1], in_data[IN_W-2:0]};
  assign xw   = $signed({{(W-IN_W){x[IN_W-1]}}, x});
  assign acc1 = xw - qmul(y2, B1C);
  assign ynew = clip(acc1);
  assign acc2 = $signed({{CW{ynew[SW-1]}}, ynew}) + qmul(d2, B2C);
  assign z    = clip(acc2);

  always_ff @(posedge clk) begin
    if (rst) begin
      y1 <= '0; y2 <= '0; d1 <= '0; d2 <= '0;
      cnt <= '0; out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        y2 <= y1;
        y1 <= ynew;
        if (cnt == LAST) begin
          cnt <= '0;
          d2 <= d1;
          d1 <= ynew;
          out_data <= z;
          out_valid <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
  assert_from_accept_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(y1) && $stable(y2) && $stable(d1) && $stable(d2) && $stable(cnt)));
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !out_valid && y1 == '0 && d2 == '0));
endmodule

// File: tb/test_qtr_tuner.sv
module test_qtr_tuner;
  localparam int  NM   = 40;
  localparam longint B1V = 32735;
  localparam longint B2V = 32768 - (32768 - B1V) * NM;
  localparam longint MAXV = 8388607;
  localparam longint MINV = -8388608;
  localparam real PI = 3.14159265358979;
  localparam real FS = 2.0e6;

  // stimulus table: [31:16] code held for one group, [3:0] idle cycles after each sample
  localparam int NV = 10;
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'h8000_0000, 32'hFFFF_0000, 32'h0000_0001, 32'h8001_0002,
    32'h7FFF_0000, 32'hC000_0003, 32'h4000_0000, 32'hFFFF_0001,
    32'h0000_0000, 32'h1234_0002
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic out_valid;
  logic signed [23:0] out_data;

  qtr_tuner i_qtr_tuner (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
                         .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R8";
  longint my1, my2, md1, md2;
  int mcnt;
  bit exp_v = 1'b0;
  longint exp_d = 0;
  int n_out = 0, skip = 0;
  bit collect = 1'b0, hit_rail = 1'b0;
  real energy = 0.0;

  function automatic longint satv(longint v);
    return (v > MAXV) ? MAXV : (v < MINV) ? MINV : v;
  endfunction
  function automatic longint rq(longint a, longint c);
    return (a * c + 16384) >>> 15;
  endfunction

  task automatic model_clear();
    my1 = 0; my2 = 0; md1 = 0; md2 = 0; mcnt = 0;
  endtask

  task automatic check_cycle();
    n_checks++;
    if (out_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s out_valid actual %0b expected %0b", cur_req, out_valid, exp_v);
    end else if (exp_v) begin
      if (longint'(out_data) != exp_d) begin
        n_fail++;
        $display("FAIL %s out_data actual %0d expected %0d", cur_req, out_data, exp_d);
      end
      if (longint'(out_data) == MAXV || longint'(out_data) == MINV) hit_rail = 1'b1;
      if (collect && n_out >= skip) energy += real'(out_data) * real'(out_data);
      n_out++;
    end
  endtask

  task automatic step(bit v, logic [15:0] d);
    longint x, y, z;
    @(negedge clk);
    check_cycle();
    in_valid = v; in_data = d;
    exp_v = 1'b0;
    if (v) begin
      x = longint'(d) - 32768;                 // R1
      y = satv(x - rq(my2, B1V));              // R2, R3
      my2 = my1; my1 = y;
      if (mcnt == NM - 1) begin                // R4
        mcnt = 0;
        z = satv(y + rq(md2, B2V));            // R5
        md2 = md1; md1 = y;
        exp_v = 1'b1; exp_d = z;
      end else mcnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_cycle();
    in_valid = 1'b0; rst = 1'b1; exp_v = 1'b0;
    repeat (2) @(negedge clk);
    cur_req = "R8";
    n_checks++;
    if (out_valid !== 1'b0 || out_data !== 24'sd0) begin
      n_fail++;
      $display("FAIL R8 reset state actual %0b/%0d expected 0/0", out_valid, out_data);
    end
    rst = 1'b0;
    model_clear();
  endtask

  task automatic tone_run(real f1, real a1, real f2, real a2, real f3, real a3, int groups);
    real v;
    int c;
    for (int i = 0; i < groups * NM; i++) begin
      v = 32767.0 + a1 * 32767.0 * $cos(2.0 * PI * f1 * i / FS)
                  + a2 * 32767.0 * $cos(2.0 * PI * f2 * i / FS)
                  + a3 * 32767.0 * $cos(2.0 * PI * f3 * i / FS);
      c = $rtoi(v + 0.5);
      if (c < 0) c = 0;
      if (c > 65535) c = 65535;
      step(1'b1, 16'(c));
    end
    step(1'b0, 16'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    real e_in, e_out;
    model_clear();
    do_reset();

    // R8: first output after exactly M accepted samples, with idle gaps (R7)
    cur_req = "R8";
    for (int i = 0; i < NM; i++) begin
      step(1'b1, 16'(1000 * i));
      if (i % 3 == 0) step(1'b0, 16'hFFFF);
    end
    step(1'b0, 16'h0);

    // R1 R2 R4 R5 R7 R9: table of held codes with idle gaps, state carried across groups
    cur_req = "R9";
    foreach (VEC[k]) begin
      for (int j = 0; j < NM; j++) begin
        step(1'b1, VEC[k][31:16]);
        for (int g = 0; g < int'(VEC[k][3:0]); g++) step(1'b0, ~VEC[k][31:16]);
      end
    end
    step(1'b0, 16'h0);

    // R3: square wave at quarter rate drives resonator to its limits
    cur_req = "R3";
    hit_rail = 1'b0;
    for (int i = 0; i < 60 * NM; i++) step(1'b1, ((i % 4) < 2) ? 16'hFFFF : 16'h0000);
    step(1'b0, 16'h0);
    n_checks++;
    if (!hit_rail) begin
      n_fail++;
      $display("FAIL R3 rail reached actual 0 expected 1");
    end

    // R8: reset in the middle of a group restarts the count
    cur_req = "R8";
    for (int i = 0; i < 17; i++) step(1'b1, 16'h9000);
    do_reset();
    for (int i = 0; i < 2 * NM; i++) step(1'b1, 16'(i * 700));
    step(1'b0, 16'h0);

    // R2 R4 R5: mixed tones, bit-exact
    cur_req = "R5";
    do_reset();
    tone_run(508.0e3, 0.1, 493.0e3, 0.05, 293.0e3, 0.1, 120);

    // R10: attenuation of the far tone relative to the near tone
    cur_req = "R10";
    do_reset();
    collect = 1'b1; energy = 0.0; n_out = 0; skip = 100;
    tone_run(508.0e3, 0.1, 0.0, 0.0, 0.0, 0.0, 300);
    e_in = energy;
    do_reset();
    energy = 0.0; n_out = 0;
    tone_run(293.0e3, 0.1, 0.0, 0.0, 0.0, 0.0, 300);
    e_out = energy;
    collect = 1'b0;
    n_checks++;
    if (!(e_in >= 64.0 * e_out)) begin
      n_fail++;
      $display("FAIL R10 energy ratio actual %f expected >= 64", e_in / ((e_out > 0.0) ? e_out : 1.0));
    end

    step(1'b0, 16'h0);
    step(1'b0, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule